// File: doc/BRIEF.md
# PCI Interrupt Swizzle and Router

This block gathers the level-sensitive interrupt pins of a row of PCI device slots and turns them into the sixteen request lines of a legacy interrupt controller. Every slot has four pins (INTA through INTD). The block first rotates each pin by its slot number onto one of four shared lines, named PIRQA to PIRQD. A PIRQ line is the OR of every slot pin that lands on it. Four byte-wide routing registers then steer each PIRQ line to one controller input, or leave it unconnected. When several PIRQ lines are steered to the same input, that input carries the OR of their levels.

Software programs the routing bytes through a simple register port. A write takes one cycle and has no handshake. A read returns data combinationally from the addressed byte. The pin inputs and the request outputs are plain levels, sampled and driven every cycle. No data stream crosses the block's edge, so it has no valid/ready interface and never applies back-pressure. A parameter selects one of two reset profiles for the routing bytes.

Top module: `pirq_router_top`

## Requirements
- R1: The pin level of slot s (s ≥ 1), pin i (INTA=0, INTB=1, INTC=2, INTD=3) is carried on `dev_int[4*s+i]`. It drives PIRQ line (i + s − 1) mod 4, where PIRQA=0 and PIRQD=3.
- R2: Writing `cfg_wdata` with `cfg_wr_en` high at offset 0x60+k (k = 0..3) stores the byte that routes PIRQ k. Reading `cfg_rdata` at that offset returns the stored byte in the same cycle.
- R3: A routing byte with a value v below 16 steers its PIRQ line to `irq_level[v]`.
- R4: A routing byte of 16 or more, for example 0x10 or 0x80, disconnects its PIRQ line, so the line drives no output.
- R5: When two or more PIRQ lines are steered to the same output, that output is the OR of their levels.
- R6: During reset `irq_level` is 0. With RESET_PROFILE=1, the routing bytes reset to 0x0A, 0x0A, 0x0B and 0x0B for PIRQA..D. With RESET_PROFILE=0, all four reset to 0x80.
- R7: `irq_level` is registered. Pin levels present at a clock edge appear on the output after that edge. A routing write accepted at edge k changes the output from edge k+1.
- R8: A write to any offset outside 0x60..0x63 changes no routing byte. A read of any such offset returns 0.
- R9: The pins of slot 0 (`dev_int[3:0]`) never affect `irq_level`.
- R10: An output with no connected, asserted PIRQ line steered to it is driven low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_wr_en | input | 1 | Write strobe for the routing bytes |
| cfg_addr | input | 8 | Configuration byte offset, used for both read and write |
| cfg_wdata | input | 8 | Write data |
| cfg_rdata | output | 8 | Read data for `cfg_addr`, combinational |
| dev_int | input | 4*NUM_SLOTS | Per-slot, per-pin interrupt levels; bit 4*s+i holds slot s, pin i |
| irq_level | output | IRQ_LINES | Registered request levels to the interrupt controller |

## Verification
A corrupted routing byte shows up on the read port at once. On `irq_level` it shows as an interrupt moved to the wrong output, or as a lost one, one edge after the first pin that uses that PIRQ line rises. A wrong rotation term puts a slot's request on a neighbouring output in the cycle after that slot asserts. A wrong disable compare shows as a stray request when a byte of 16 or more is written. The scoreboard models the routing bytes independently and checks `irq_level` every cycle that it drives. Any such defect therefore appears no later than the first stimulus that uses the affected path.

// File: rtl/pirq_route_pkg.sv
package pirq_route_pkg;
  localparam int PIRQ_COUNT    = 4;
  localparam int PINS_PER_SLOT = 4;
  localparam logic [7:0] ROUTE_BASE = 8'h60;
  localparam logic [7:0] ROUTE_OFF  = 8'h80;

  typedef logic [7:0] route_t;

  typedef enum int {
    PROFILE_ALL_OFF = 0,
    PROFILE_SPLIT   = 1
  } profile_e;

  // Reset value of routing byte idx under a given profile.
  function automatic route_t reset_route(input int prof, input int idx);
    if (prof == PROFILE_SPLIT) begin
      return (idx < 2) ? 8'h0a : 8'h0b;
    end
    return ROUTE_OFF;
  endfunction
endpackage

// File: rtl/pirq_swizzle.sv
module pirq_swizzle
  import pirq_route_pkg::*;
#(
  parameter int NUM_SLOTS = 8,
  localparam int UPPER_W = (NUM_SLOTS - 1) * PINS_PER_SLOT
) (
  input  logic [UPPER_W-1:0]    slot_pins_i,  // slots 1..NUM_SLOTS-1
  output logic [PIRQ_COUNT-1:0] pirq_o
);
  always_comb begin
    pirq_o = '0;
    for (int s = 1; s < NUM_SLOTS; s++) begin
      for (int i = 0; i < PINS_PER_SLOT; i++) begin
        if (slot_pins_i[(s - 1) * PINS_PER_SLOT + i]) begin
          pirq_o[2'(i + s - 1)] = 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/pirq_route_regs.sv
module pirq_route_regs
  import pirq_route_pkg::*;
#(
  parameter int RESET_PROFILE = 1
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en_i,
  input  logic [7:0]                    addr_i,
  input  logic [7:0]                    wdata_i,
  output logic [7:0]                    rdata_o,
  output logic [PIRQ_COUNT-1:0][7:0]    route_o
);
  logic       hit;
  logic [1:0] idx;

  assign hit = (addr_i[7:2] == ROUTE_BASE[7:2]);
  assign idx = addr_i[1:0];

  generate
    for (genvar k = 0; k < PIRQ_COUNT; k++) begin : g_byte
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          route_o[k] <= reset_route(RESET_PROFILE, k);
        end else if (wr_en_i && hit && (idx == 2'(k))) begin
          route_o[k] <= wdata_i;
        end
      end
    end
  endgenerate

  assign rdata_o = hit ? route_o[idx] : 8'h00;

  // R2
  route_wr_land_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && hit) |=> (route_o[$past(idx)] == $past(wdata_i)));

  // R8
  route_miss_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && !hit) |=> $stable(route_o));
endmodule

// File: rtl/pirq_irq_fanin.sv
module pirq_irq_fanin
  import pirq_route_pkg::*;
#(
  parameter int IRQ_LINES = 16,
  localparam int SEL_W = $clog2(IRQ_LINES)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [PIRQ_COUNT-1:0]      pirq_i,
  input  logic [PIRQ_COUNT-1:0][7:0] route_i,
  output logic [IRQ_LINES-1:0]       irq_q
);
  logic [IRQ_LINES-1:0]  irq_nxt;
  logic [PIRQ_COUNT-1:0] live;

  generate
    for (genvar p = 0; p < PIRQ_COUNT; p++) begin : g_live
      assign live[p] = (route_i[p] < 8'(IRQ_LINES));
    end
  endgenerate

  always_comb begin
    irq_nxt = '0;
    for (int p = 0; p < PIRQ_COUNT; p++) begin
      if (live[p] && pirq_i[p]) begin
        irq_nxt[route_i[p][SEL_W-1:0]] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= '0;
    else        irq_q <= irq_nxt;
  end

  // R10
  irq_needs_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|irq_q) |-> $past(|pirq_i));

  // R4
  all_off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (~|live) |=> (~|irq_q));

  // R5
  fanin_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(irq_q) <= PIRQ_COUNT);
endmodule

// File: rtl/pirq_router_top.sv
module pirq_router_top
  import pirq_route_pkg::*;
#(
  parameter int NUM_SLOTS     = 8,
  parameter int IRQ_LINES     = 16,
  parameter int RESET_PROFILE = 1,
  localparam int PIN_W = NUM_SLOTS * PINS_PER_SLOT
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_wr_en,
  input  logic [7:0]           cfg_addr,
  input  logic [7:0]           cfg_wdata,
  output logic [7:0]           cfg_rdata,
  input  logic [PIN_W-1:0]     dev_int,
  output logic [IRQ_LINES-1:0] irq_level
);
  logic [PIRQ_COUNT-1:0]      pirq;
  logic [PIRQ_COUNT-1:0][7:0] route;

  pirq_swizzle #(.NUM_SLOTS(NUM_SLOTS)) u_swz (
    .slot_pins_i (dev_int[PIN_W-1:PINS_PER_SLOT]),
    .pirq_o      (pirq)
  );

  pirq_route_regs #(.RESET_PROFILE(RESET_PROFILE)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en_i (cfg_wr_en),
    .addr_i  (cfg_addr),
    .wdata_i (cfg_wdata),
    .rdata_o (cfg_rdata),
    .route_o (route)
  );

  pirq_irq_fanin #(.IRQ_LINES(IRQ_LINES)) u_fanin (
    .clk     (clk),
    .rst_n   (rst_n),
    .pirq_i  (pirq),
    .route_i (route),
    .irq_q   (irq_level)
  );

  // R9
  slot0_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(|dev_int[PINS_PER_SLOT-1:0]) && $past(~|dev_int[PIN_W-1:PINS_PER_SLOT]))
      |-> (~|irq_level));
endmodule

// File: tb/pirq_router_top_tb.sv
module pirq_router_top_tb;
  localparam int NS = 8;
  localparam int W  = NS * 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_wr_en = 1'b0;
  logic [7:0]    cfg_addr = 8'h00;
  logic [7:0]    cfg_wdata = 8'h00;
  logic [7:0]    cfg_rdata;
  logic [W-1:0]  dev_int = '0;
  logic [15:0]   irq_level;

  logic [7:0]    p0_addr = 8'h60;
  logic [7:0]    p0_rdata;
  logic [15:0]   p0_irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [7:0]  mreg [4];
  logic [15:0] exp_q [$];
  string       tag_q [$];

  always #2.5 clk = ~clk;

  pirq_router_top #(.NUM_SLOTS(NS), .IRQ_LINES(16), .RESET_PROFILE(1)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .dev_int(dev_int),
    .irq_level(irq_level)
  );

  pirq_router_top #(.NUM_SLOTS(NS), .IRQ_LINES(16), .RESET_PROFILE(0)) u_dut_p0 (
    .clk(clk), .rst_n(rst_n), .cfg_wr_en(1'b0), .cfg_addr(p0_addr),
    .cfg_wdata(8'h00), .cfg_rdata(p0_rdata), .dev_int(dev_int),
    .irq_level(p0_irq)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Expected output from the requirements, using the model's routing bytes.
  function automatic logic [15:0] model_irq(input logic [W-1:0] pins);
    logic [15:0] e = '0;
    for (int s = 1; s < NS; s++) begin
      for (int i = 0; i < 4; i++) begin
        if (pins[4*s+i]) begin
          int p = (i + s - 1) % 4;
          if (mreg[p] < 8'd16) e[mreg[p][3:0]] = 1'b1;
        end
      end
    end
    return e;
  endfunction

  task automatic step(input logic [W-1:0] pins, input bit wr,
                      input logic [7:0] a, input logic [7:0] d, input string req);
    @(negedge clk);
    dev_int   = pins;
    cfg_wr_en = wr;
    cfg_addr  = a;
    cfg_wdata = d;
    exp_q.push_back(model_irq(pins));
    tag_q.push_back(req);
    if (wr && a >= 8'h60 && a <= 8'h63) mreg[a - 8'h60] = d;
  endtask

  task automatic rd(input logic [7:0] a, input logic [7:0] exp, input string req);
    @(negedge clk);
    cfg_wr_en = 1'b0;
    cfg_addr  = a;
    #1;
    check(req, {8'h00, cfg_rdata}, {8'h00, exp});
  endtask

  function automatic logic [W-1:0] pin(input int s, input int i);
    logic [W-1:0] v = '0;
    v[4*s+i] = 1'b1;
    return v;
  endfunction

  // Monitor: pops one expected value per edge after the driver pushes one.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() > 0) begin
        string t = tag_q.pop_front();
        check(t, irq_level, exp_q.pop_front());
      end
    end
  end

  task automatic finish_sim();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #500000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_sim();
    end
  end

  initial begin
    mreg[0] = 8'h0a; mreg[1] = 8'h0a; mreg[2] = 8'h0b; mreg[3] = 8'h0b;
    repeat (4) @(posedge clk);
    #1;
    check("R6 reset output", irq_level, 16'h0000);
    rst_n = 1'b1;
    rd(8'h60, 8'h0a, "R6 profile1 A");
    rd(8'h61, 8'h0a, "R6 profile1 B");
    rd(8'h62, 8'h0b, "R6 profile1 C");
    rd(8'h63, 8'h0b, "R6 profile1 D");
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      p0_addr = 8'h60 + 8'(k);
      #1;
      check("R6 profile0 byte", {8'h00, p0_rdata}, 16'h0080);
    end
    rd(8'h5f, 8'h00, "R8 read outside");

    // R1 rotation across slots and pins
    step(pin(1, 0), 0, 8'h00, 8'h00, "R1 s1 INTA");
    step(pin(2, 0), 0, 8'h00, 8'h00, "R1 s2 INTA");
    step(pin(3, 0), 0, 8'h00, 8'h00, "R1 s3 INTA");
    step(pin(4, 1), 0, 8'h00, 8'h00, "R1 s4 INTB");
    step(pin(7, 3), 0, 8'h00, 8'h00, "R1 s7 INTD");

    // R7 write latency, R2 readback
    step(pin(3, 0), 1, 8'h62, 8'h05, "R7 write cycle old route");
    step(pin(3, 0), 0, 8'h00, 8'h00, "R7 next cycle new route");
    rd(8'h62, 8'h05, "R2 readback");

    // R4 disable, R3 steering
    step(pin(4, 0), 1, 8'h63, 8'h80, "R4 set 0x80");
    step(pin(4, 0), 1, 8'h63, 8'h10, "R4 0x80 disconnected");
    step(pin(4, 0), 1, 8'h63, 8'h0f, "R4 0x10 disconnected");
    step(pin(4, 0), 1, 8'h63, 8'h00, "R3 irq15");
    step(pin(4, 0), 0, 8'h00, 8'h00, "R3 irq0");

    // R5 sharing, R10 idle low
    step('0, 1, 8'h60, 8'h07, "R10 idle");
    step('0, 1, 8'h61, 8'h07, "R10 idle");
    step(pin(1, 0), 0, 8'h00, 8'h00, "R5 A only");
    step(pin(2, 0), 0, 8'h00, 8'h00, "R5 B only");
    step(pin(1, 0) | pin(2, 0), 0, 8'h00, 8'h00, "R5 both");
    step('0, 0, 8'h00, 8'h00, "R10 none");

    // R9 slot 0 ignored
    step({{(W-4){1'b0}}, 4'hf}, 0, 8'h00, 8'h00, "R9 slot0");
    step({{(W-4){1'b0}}, 4'hf}, 0, 8'h00, 8'h00, "R9 slot0 held");

    // R8 writes outside the window
    step(pin(1, 0), 1, 8'h64, 8'haa, "R8 write 0x64");
    step(pin(1, 0), 1, 8'h5f, 8'h03, "R8 write 0x5f");
    step(pin(1, 0), 0, 8'h00, 8'h00, "R8 output unchanged");
    rd(8'h60, 8'h07, "R8 A unchanged");
    rd(8'h61, 8'h07, "R8 B unchanged");
    rd(8'h62, 8'h05, "R8 C unchanged");
    rd(8'h63, 8'h00, "R8 D unchanged");

    // Mixed traffic
    for (int n = 0; n < 300; n++) begin
      logic [W-1:0] pv = W'($urandom);
      bit           w  = ($urandom % 4) == 0;
      logic [7:0]   a  = 8'h5e + 8'($urandom % 8);
      logic [7:0]   d  = (($urandom % 3) == 0) ? 8'($urandom) : 8'($urandom % 16);
      step(pv, w, a, d, "R3 R5 mixed");
    end
    step('0, 0, 8'h00, 8'h00, "R10 drain");
    repeat (3) @(negedge clk);
    check("R4 profile0 output", p0_irq, 16'h0000);
    done = 1'b1;
    finish_sim();
  end
endmodule